// File: doc/BRIEF.md
# Lock-Gated PLL Control Register Block with Unlock Sequence

This block sits on a simple peripheral bus and owns the control and configuration values of a clock multiplier. Software writes a control word (an enable bit and a connect bit) and a configuration word. Both land in holding registers only. The values reach the active registers that drive the PLL only when an unlock sequence completes. The unlock sequence is a write of 0xAA to the feed register, followed by a write of 0x55 to the same register in the very next clock cycle.

The block drives the PLL enable and configuration. It also drives a connect output that selects the PLL as the clock source. That output stays low unless the active enable bit is set, the active connect bit is set and the lock input is high.

A power-down request clears the active values at once, so the PLL is turned off and disconnected. This clearing does not happen when the USB wake-up enable and the USB clock-needed inputs are both high. In that case the request is refused and the PLL is left as it is.

Top module: `pll_feed_ctl`

## Requirements
- R1: During and after reset, `pll_en_o`, `pll_con_o` and `pll_cfg_o` are 0, and reads of the control, configuration and feed registers (word addresses 0, 1, 2) return 0x00.
- R2: A write to address 0 (bit 0 = enable, bit 1 = connect) or to address 1 (configuration in bits [CFG_W-1:0]) is read back from that address on the next cycle. It leaves `pll_en_o`, `pll_con_o` and `pll_cfg_o` unchanged.
- R3: A write of 0xAA to address 2, directly followed in the next clock cycle by a write of 0x55 to address 2, copies the held control and configuration values to the active registers at the clock edge of the 0x55 write.
- R4: If the first feed write is not 0xAA, or the second is not 0x55, the active registers keep their values.
- R5: Any cycle between the two feed writes cancels the sequence and the active registers keep their values. This includes an idle cycle and a read of any register.
- R6: `pll_con_o` is high exactly when the active enable bit is 1, the active connect bit is 1 and `lock_i` is 1. It follows `lock_i` in the same cycle.
- R7: `pll_en_o` equals the active enable bit. An active value with connect=1 and enable=0 gives `pll_en_o`=0 and `pll_con_o`=0.
- R8: A power-down request that is not vetoed raises `pd_grant_o` in the same cycle. At that clock edge it clears the active enable, connect and configuration to 0. The held values are kept, and they take effect again only after a new feed.
- R9: While `usb_wake_en_i` and `usb_need_clk_i` are both 1, a power-down request gives `pd_grant_o`=0 and changes nothing. If only one of the two inputs is high, the request is granted.
- R10: A read of address 3 returns the status word: bit 0 = active enable, bit 1 = active connect, bit 2 = `lock_i`, bits [CFG_W+2:3] = active configuration.
- R11: When a granted power-down request falls in the same cycle as the completing 0x55 feed write, the power-down wins and the active registers end up at 0.
- R12: A feed write of 0xAA arms the sequence for the next cycle even when the sequence is already armed. The series 0xAA, 0xAA, 0x55 on three consecutive cycles therefore completes a feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 control, 1 configuration, 2 feed, 3 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| lock_i | input | 1 | PLL lock indication |
| pd_req_i | input | 1 | Power-down request, one cycle |
| usb_wake_en_i | input | 1 | USB activity may wake the device |
| usb_need_clk_i | input | 1 | USB still needs its clock |
| pll_en_o | output | 1 | PLL enable |
| pll_con_o | output | 1 | PLL selected as clock source |
| pll_cfg_o | output | CFG_W | Active PLL configuration |
| pd_grant_o | output | 1 | Power-down request accepted |

## Verification
The bench tries every byte value in the first feed position and every byte value in the second, so a key compare that ignores a bit, or that accepts the keys in either order, shows up as a wrong status readback. It puts an idle cycle and a status read between the two feed writes. A detector that stays armed across non-feed cycles would then commit when it should not. The 0xAA, 0xAA, 0x55 series catches a detector that disarms on a repeated first key. A power-down that collides with a completing feed catches the wrong priority. It sweeps all control values against both lock levels, which exposes a connect output that ignores the enable bit or the lock input. Its power-down checks cover all four veto combinations, so a veto that tests only one of the USB inputs is caught.

// File: rtl/pllfc_pkg.sv
package pllfc_pkg;
  localparam int unsigned BUS_DW = 8;
  localparam logic [BUS_DW-1:0] FEED_KEY_A = 8'hAA;
  localparam logic [BUS_DW-1:0] FEED_KEY_B = 8'h55;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_FEED = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pllfc_feed_seq.sv
module pllfc_feed_seq
  import pllfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              feed_wr_i,
  input  logic [BUS_DW-1:0] feed_data_i,
  output logic              done_o
);
  logic armed_q;
  logic key_a, key_b;

  assign key_a = feed_wr_i && (feed_data_i == FEED_KEY_A);
  assign key_b = feed_wr_i && (feed_data_i == FEED_KEY_B);

  // armed for exactly one cycle after a first-key write; anything else disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= key_a;
  end

  assign done_o = armed_q && key_b;

  assert_feed_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(feed_wr_i && feed_data_i == FEED_KEY_A));
endmodule

// File: rtl/pllfc_pwr.sv
module pllfc_pwr (
  input  logic pd_req_i,
  input  logic usb_wake_en_i,
  input  logic usb_need_clk_i,
  output logic grant_o
);
  logic veto;
  assign veto    = usb_wake_en_i && usb_need_clk_i;
  assign grant_o = pd_req_i && !veto;
endmodule

// File: rtl/pllfc_regs.sv
module pllfc_regs #(
  parameter int unsigned CFG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [1:0]       ctrl_d_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_d_i,
  input  logic             commit_i,
  input  logic             clear_i,
  output logic [1:0]       hold_ctrl_o,
  output logic [CFG_W-1:0] hold_cfg_o,
  output logic [1:0]       act_ctrl_o,
  output logic [CFG_W-1:0] act_cfg_o
);
  logic [1:0]       hold_ctrl_q, act_ctrl_q;
  logic [CFG_W-1:0] hold_cfg_q,  act_cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_ctrl_q <= '0;
      hold_cfg_q  <= '0;
    end else begin
      if (ctrl_wr_i) hold_ctrl_q <= ctrl_d_i;
      if (cfg_wr_i)  hold_cfg_q  <= cfg_d_i;
    end
  end

  // power-down outranks a completing feed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ctrl_q <= '0;
      act_cfg_q  <= '0;
    end else if (clear_i) begin
      act_ctrl_q <= '0;
      act_cfg_q  <= '0;
    end else if (commit_i) begin
      act_ctrl_q <= hold_ctrl_q;
      act_cfg_q  <= hold_cfg_q;
    end
  end

  assign hold_ctrl_o = hold_ctrl_q;
  assign hold_cfg_o  = hold_cfg_q;
  assign act_ctrl_o  = act_ctrl_q;
  assign act_cfg_o   = act_cfg_q;

  assert_act_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clear_i) |=> $stable({act_ctrl_q, act_cfg_q}));

  assert_pd_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (act_ctrl_q == '0 && act_cfg_q == '0));
endmodule

// File: rtl/pll_feed_ctl.sv
module pll_feed_ctl
  import pllfc_pkg::*;
#(
  parameter int unsigned CFG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              lock_i,
  input  logic              pd_req_i,
  input  logic              usb_wake_en_i,
  input  logic              usb_need_clk_i,
  output logic              pll_en_o,
  output logic              pll_con_o,
  output logic [CFG_W-1:0]  pll_cfg_o,
  output logic              pd_grant_o
);
  localparam int unsigned STAT_W = CFG_W + 3;

  logic             wr_ctrl, wr_cfg, wr_feed, feed_done, pd_grant;
  logic [1:0]       hold_ctrl, act_ctrl;
  logic [CFG_W-1:0] hold_cfg, act_cfg;
  logic [STAT_W-1:0] stat;

  assign wr_ctrl = bus_sel_i && bus_wr_i && (bus_addr_i == REG_CTRL);
  assign wr_cfg  = bus_sel_i && bus_wr_i && (bus_addr_i == REG_CFG);
  assign wr_feed = bus_sel_i && bus_wr_i && (bus_addr_i == REG_FEED);

  pllfc_feed_seq u_feed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .feed_wr_i   (wr_feed),
    .feed_data_i (bus_wdata_i),
    .done_o      (feed_done)
  );

  pllfc_pwr u_pwr (
    .pd_req_i       (pd_req_i),
    .usb_wake_en_i  (usb_wake_en_i),
    .usb_need_clk_i (usb_need_clk_i),
    .grant_o        (pd_grant)
  );

  pllfc_regs #(.CFG_W(CFG_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (wr_ctrl),
    .ctrl_d_i    (bus_wdata_i[1:0]),
    .cfg_wr_i    (wr_cfg),
    .cfg_d_i     (bus_wdata_i[CFG_W-1:0]),
    .commit_i    (feed_done),
    .clear_i     (pd_grant),
    .hold_ctrl_o (hold_ctrl),
    .hold_cfg_o  (hold_cfg),
    .act_ctrl_o  (act_ctrl),
    .act_cfg_o   (act_cfg)
  );

  assign stat = {act_cfg, lock_i, act_ctrl[1], act_ctrl[0]};

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      unique case (bus_addr_i)
        REG_CTRL: bus_rdata_o = BUS_DW'(hold_ctrl);
        REG_CFG:  bus_rdata_o = BUS_DW'(hold_cfg);
        REG_FEED: bus_rdata_o = '0;
        REG_STAT: bus_rdata_o = BUS_DW'(stat);
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign pll_en_o   = act_ctrl[0];
  assign pll_con_o  = act_ctrl[0] && act_ctrl[1] && lock_i;
  assign pll_cfg_o  = act_cfg;
  assign pd_grant_o = pd_grant;

  assert_veto_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_req_i && usb_wake_en_i && usb_need_clk_i && !feed_done)
      |=> $stable({pll_en_o, pll_cfg_o}));

  assert_con_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_con_o |-> (pll_en_o && lock_i));
endmodule

// File: tb/tb_pll_feed_ctl.sv
`timescale 1ns/1ps
module tb_pll_feed_ctl;
  localparam int CFG_W = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_sel_i = 1'b0, bus_wr_i = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic lock_i = 1'b0, pd_req_i = 1'b0, usb_wake_en_i = 1'b0, usb_need_clk_i = 1'b0;
  logic pll_en_o, pll_con_o, pd_grant_o;
  logic [CFG_W-1:0] pll_cfg_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model of active state
  logic m_en = 0, m_con = 0;
  logic [CFG_W-1:0] m_cfg = '0;

  always #4 clk_i = ~clk_i;

  pll_feed_ctl #(.CFG_W(CFG_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
  endtask

  task automatic idle();
    @(negedge clk_i);
    bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk_i);
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    #1 q = bus_rdata_o;
  endtask

  task automatic feed();
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); idle();
  endtask

  function automatic logic [7:0] stat_exp(input logic lk);
    return {m_cfg, lk, m_con, m_en};
  endfunction

  task automatic chk_stat(input string req);
    logic [7:0] q;
    rd(2'd3, q);
    chk(req, q, stat_exp(lock_i));
    idle();
  endtask

  task automatic pd_pulse(input logic we, input logic nc, output logic g);
    @(negedge clk_i);
    usb_wake_en_i = we; usb_need_clk_i = nc; pd_req_i = 1;
    #1 g = pd_grant_o;
    @(negedge clk_i);
    pd_req_i = 0; usb_wake_en_i = 0; usb_need_clk_i = 0;
  endtask

  task automatic set_hold(input logic [1:0] c, input logic [CFG_W-1:0] f);
    wr(2'd0, {6'd0, c}); wr(2'd1, 8'(f)); idle();
  endtask

  initial begin
    logic [7:0] q;
    logic g;
    #3;
    // R1: reset state
    chk("R1 en", pll_en_o, 0);
    chk("R1 con", pll_con_o, 0);
    chk("R1 cfg", pll_cfg_o, 0);
    @(negedge clk_i); rst_ni = 1;
    rd(2'd0, q); chk("R1 ctrl rd", q, 0);
    rd(2'd1, q); chk("R1 cfg rd", q, 0);
    rd(2'd2, q); chk("R1 feed rd", q, 0);
    rd(2'd3, q); chk("R10 stat reset", q, 0);
    idle();

    // R2: holding only
    lock_i = 1;
    set_hold(2'b11, 5'h15);
    rd(2'd0, q); chk("R2 ctrl rd", q, 8'h03);
    rd(2'd1, q); chk("R2 cfg rd", q, 8'h15);
    idle();
    chk("R2 en held", pll_en_o, 0);
    chk("R2 cfg held", pll_cfg_o, 0);
    chk("R2 con held", pll_con_o, 0);

    // R3: feed commits
    feed();
    m_en = 1; m_con = 1; m_cfg = 5'h15;
    chk("R3 en", pll_en_o, 1);
    chk("R3 cfg", pll_cfg_o, 5'h15);
    chk("R6 con locked", pll_con_o, 1);
    chk_stat("R10 stat");

    // R6/R7: all control values against both lock levels
    for (int c = 0; c < 4; c++) begin
      set_hold(c[1:0], 5'(c + 3));
      feed();
      m_en = c[0]; m_con = c[1]; m_cfg = 5'(c + 3);
      for (int lk = 0; lk < 2; lk++) begin
        @(negedge clk_i); lock_i = lk[0];
        #1;
        chk("R7 en", pll_en_o, c[0]);
        chk("R6 con", pll_con_o, c[0] & c[1] & lk[0]);
      end
      chk_stat("R10 stat sweep");
    end
    @(negedge clk_i); lock_i = 1;

    // R4: every second-key value
    for (int v = 0; v < 256; v++) begin
      set_hold(2'b01, 5'(v ^ 9));
      wr(2'd2, 8'hAA); wr(2'd2, 8'(v)); idle();
      if (v == 8'h55) begin m_en = 1; m_con = 0; m_cfg = 5'(v ^ 9); end
      chk_stat("R4 second key");
    end
    // R4: every first-key value
    for (int v = 0; v < 256; v++) begin
      set_hold(2'b11, 5'(v + 7));
      wr(2'd2, 8'(v)); wr(2'd2, 8'h55); idle();
      if (v == 8'hAA) begin m_en = 1; m_con = 1; m_cfg = 5'(v + 7); end
      chk_stat("R4 first key");
    end

    // R5: gaps cancel
    set_hold(2'b01, 5'h0A);
    wr(2'd2, 8'hAA); idle(); wr(2'd2, 8'h55); idle();
    chk_stat("R5 idle gap");
    wr(2'd2, 8'hAA); rd(2'd3, q); wr(2'd2, 8'h55); idle();
    chk_stat("R5 read gap");
    wr(2'd2, 8'hAA); wr(2'd1, 8'h0A); wr(2'd2, 8'h55); idle();
    chk_stat("R5 write gap");
    wr(2'd2, 8'h55); idle();
    chk_stat("R5 lone second key");

    // R12: AA, AA, 55
    wr(2'd2, 8'hAA); wr(2'd2, 8'hAA); wr(2'd2, 8'h55); idle();
    m_en = 1; m_con = 0; m_cfg = 5'h0A;
    chk_stat("R12 rearm");

    // R8: granted power-down
    set_hold(2'b11, 5'h1C);
    feed();
    m_en = 1; m_con = 1; m_cfg = 5'h1C;
    chk("R6 con before pd", pll_con_o, 1);
    pd_pulse(0, 0, g);
    chk("R8 grant", g, 1);
    m_en = 0; m_con = 0; m_cfg = '0;
    chk("R8 en cleared", pll_en_o, 0);
    chk("R8 con cleared", pll_con_o, 0);
    chk("R8 cfg cleared", pll_cfg_o, 0);
    rd(2'd0, q); chk("R8 hold ctrl kept", q, 8'h03);
    rd(2'd1, q); chk("R8 hold cfg kept", q, 8'h1C);
    idle();
    feed();
    m_en = 1; m_con = 1; m_cfg = 5'h1C;
    chk_stat("R8 refeed restores");

    // R9: veto combinations
    for (int k = 0; k < 4; k++) begin
      pd_pulse(k[0], k[1], g);
      chk("R9 grant", g, !(k[0] & k[1]));
      if (!(k[0] & k[1])) begin m_en = 0; m_con = 0; m_cfg = '0; end
      chk_stat("R9 state");
      if (!(k[0] & k[1])) begin
        feed(); m_en = 1; m_con = 1; m_cfg = 5'h1C;
      end
    end

    // R11: power-down beats a completing feed
    set_hold(2'b01, 5'h05);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55); pd_req_i = 1;
    idle(); pd_req_i = 0;
    m_en = 0; m_con = 0; m_cfg = '0;
    chk_stat("R11 pd priority");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule